// File: doc/BRIEF.md
# Channel Status Bit Generator for a Two-Channel Digital Audio Transmitter

This block supplies the channel status (C) bit that a two-channel digital audio transmitter places in each subframe. It keeps the frame index inside the 192-frame channel status block. For that index it picks the bit to send. The index advances once per stereo frame, so the left and right subframes of a frame carry the same bit. Encoding, preambles and the audio port lie in the blocks around it.

Two configurations exist, and an active-low select input picks between them. With the select low the block is in professional mode; with it high, in consumer mode. Each mode owns a set of static, active-low configuration pins that drive fixed bit positions. Professional mode also has a two-bit emphasis code. A serial channel status input gives the value for every other position. Where a pin drives a position, its bit is ORed with the serial input. In consumer mode, a frequency code of 11 raises a flag that marks the CD submode.

Top module: `cs_bit_gen`

## Requirements
- R1: The frame index resets to 0. It rises by one on each clock edge that sees `frame_adv_i` high, and it holds on any other edge.
- R2: After index 191, an advance returns the index to 0. `block_start_o` is high exactly while the index is 0.
- R3: At index 0, `c_bit_o` is 1 when `pro_ni` is low (professional) and 0 when `pro_ni` is high (consumer). `cs_ser_i` has no effect at this index.
- R4: In professional mode, index 1 sends `~pro_nonaudio_ni`, index 6 sends `~pro_rate_ni[0]`, index 7 sends `~pro_rate_ni[1]` and index 9 sends `~pro_chmode_ni`. Each of these bits is ORed with `cs_ser_i`.
- R5: In professional mode, `emph_i` sets bits 2, 3 and 4, and each is ORed with `cs_ser_i`. The code maps as follows (bits 2,3,4): 00 gives 1,1,1; 01 gives 1,1,0; 10 gives 1,0,0; 11 gives 0,0,0.
- R6: In consumer mode, each of these bits is the inverse of its pin, ORed with `cs_ser_i`: index 2 from `con_copy_ni`, index 3 from `con_emph_ni`, index 8 from `con_cat_ni[0]`, index 9 from `con_cat_ni[1]`, index 15 from `con_gen_ni`.
- R7: In consumer mode, index 24 sends `~fc_ni[0]` and index 25 sends `~fc_ni[1]`, each ORed with `cs_ser_i`. `cd_mode_o` is high exactly when `pro_ni` is high and `fc_ni` is 11.
- R8: Any nonzero index that the active mode's pins do not drive sends `cs_ser_i` unchanged. Pins that belong to the inactive mode have no effect on `c_bit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_adv_i | input | 1 | Advances the frame index at the end of the current stereo frame |
| cs_ser_i | input | 1 | Serial channel status bit for the current frame |
| pro_ni | input | 1 | Mode select: low = professional, high = consumer |
| pro_nonaudio_ni | input | 1 | Professional non-audio pin (bit 1, inverted) |
| emph_i | input | 2 | Professional emphasis code (bits 2 to 4) |
| pro_rate_ni | input | 2 | Professional sample rate pins (bits 6 and 7, inverted) |
| pro_chmode_ni | input | 1 | Professional channel mode pin (bit 9, inverted) |
| con_copy_ni | input | 1 | Consumer copy pin (bit 2, inverted) |
| con_emph_ni | input | 1 | Consumer emphasis pin (bit 3, inverted) |
| con_cat_ni | input | 2 | Consumer category pins (bits 8 and 9, inverted) |
| con_gen_ni | input | 1 | Consumer generation pin (bit 15, inverted) |
| fc_ni | input | 2 | Consumer frequency code (bits 24 and 25, inverted) |
| c_bit_o | output | 1 | Channel status bit for the current frame |
| block_start_o | output | 1 | High while the frame index is 0 |
| cd_mode_o | output | 1 | CD submode flag |

## Verification
The hardest case to reach is a pin-driven position that meets the serial input while the other mode's pins hold opposite values. At the ports this can only be seen once the index has been walked to that exact position. The bench runs each of 32 pin configurations for two full blocks: the first with the serial input at 0, which exposes the pin values, and the second at 1, which exposes the OR. During that run the inactive mode's pins are set to the complement of the active ones, and the bench checks every frame against an index it keeps itself. Cycles in which no advance arrives test the hold, and an advance from index 191 tests the wrap.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned BLOCK_FRAMES = 192;
  localparam int unsigned PIN_SPAN     = 32;

  typedef struct packed {
    logic       nonaudio_n;
    logic [1:0] emph;
    logic [1:0] rate_n;
    logic       chmode_n;
  } pro_pins_t;

  typedef struct packed {
    logic       copy_n;
    logic       emph_n;
    logic [1:0] cat_n;
    logic       gen_n;
    logic [1:0] fc_n;
  } con_pins_t;
endpackage

// File: rtl/cs_frame_counter.sv
module cs_frame_counter #(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned IW = $clog2(FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(FRAMES - 1);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            idx_q <= '0;
    else if (adv_i) begin
      if (idx_q == LAST)    idx_q <= '0;
      else                  idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o = idx_q;

  assert_advance_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && idx_q != LAST) |=> idx_q == $past(idx_q) + 1'b1);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && idx_q == LAST) |=> idx_q == '0);
endmodule

// File: rtl/cs_pin_map.sv
module cs_pin_map
  import cs_pkg::*;
#(
  parameter int unsigned SPAN = PIN_SPAN
) (
  input  logic            pro_mode_i,
  input  pro_pins_t       pro_i,
  input  con_pins_t       con_i,
  output logic [SPAN-1:0] val_o,
  output logic [SPAN-1:0] en_o
);
  logic [SPAN-1:0] pro_val, pro_en, con_val, con_en;

  always_comb begin
    pro_val = '0;
    pro_en  = '0;
    pro_val[1] = ~pro_i.nonaudio_n;
    // emphasis code is a thermometer over bits 4..2
    pro_val[2] = ~(pro_i.emph[1] & pro_i.emph[0]);
    pro_val[3] = ~pro_i.emph[1];
    pro_val[4] = ~(pro_i.emph[1] | pro_i.emph[0]);
    pro_val[6] = ~pro_i.rate_n[0];
    pro_val[7] = ~pro_i.rate_n[1];
    pro_val[9] = ~pro_i.chmode_n;
    pro_en[1] = 1'b1; pro_en[2] = 1'b1; pro_en[3] = 1'b1; pro_en[4] = 1'b1;
    pro_en[6] = 1'b1; pro_en[7] = 1'b1; pro_en[9] = 1'b1;
  end

  always_comb begin
    con_val = '0;
    con_en  = '0;
    con_val[2]  = ~con_i.copy_n;
    con_val[3]  = ~con_i.emph_n;
    con_val[8]  = ~con_i.cat_n[0];
    con_val[9]  = ~con_i.cat_n[1];
    con_val[15] = ~con_i.gen_n;
    con_val[24] = ~con_i.fc_n[0];
    con_val[25] = ~con_i.fc_n[1];
    con_en[2] = 1'b1; con_en[3] = 1'b1; con_en[8] = 1'b1; con_en[9] = 1'b1;
    con_en[15] = 1'b1; con_en[24] = 1'b1; con_en[25] = 1'b1;
  end

  assign val_o = pro_mode_i ? pro_val : con_val;
  assign en_o  = pro_mode_i ? pro_en  : con_en;
endmodule

// File: rtl/cs_bit_gen.sv
module cs_bit_gen
  import cs_pkg::*;
#(
  parameter int unsigned FRAMES = BLOCK_FRAMES,
  parameter int unsigned SPAN   = PIN_SPAN,
  localparam int unsigned IW = $clog2(FRAMES),
  localparam int unsigned SW = $clog2(SPAN)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_adv_i,
  input  logic       cs_ser_i,
  input  logic       pro_ni,
  input  logic       pro_nonaudio_ni,
  input  logic [1:0] emph_i,
  input  logic [1:0] pro_rate_ni,
  input  logic       pro_chmode_ni,
  input  logic       con_copy_ni,
  input  logic       con_emph_ni,
  input  logic [1:0] con_cat_ni,
  input  logic       con_gen_ni,
  input  logic [1:0] fc_ni,
  output logic       c_bit_o,
  output logic       block_start_o,
  output logic       cd_mode_o
);
  logic [IW-1:0]   idx;
  logic [SPAN-1:0] pin_val, pin_en;
  pro_pins_t       pro_pins;
  con_pins_t       con_pins;
  logic            in_span;
  logic [SW-1:0]   sel;

  cs_frame_counter #(.FRAMES(FRAMES)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (frame_adv_i),
    .idx_o (idx)
  );

  assign pro_pins = '{nonaudio_n: pro_nonaudio_ni, emph: emph_i,
                      rate_n: pro_rate_ni, chmode_n: pro_chmode_ni};
  assign con_pins = '{copy_n: con_copy_ni, emph_n: con_emph_ni,
                      cat_n: con_cat_ni, gen_n: con_gen_ni, fc_n: fc_ni};

  cs_pin_map #(.SPAN(SPAN)) u_map (
    .pro_mode_i(~pro_ni),
    .pro_i     (pro_pins),
    .con_i     (con_pins),
    .val_o     (pin_val),
    .en_o      (pin_en)
  );

  assign in_span = (idx < IW'(SPAN));
  assign sel     = idx[SW-1:0];

  always_comb begin
    if (idx == '0)                  c_bit_o = ~pro_ni;
    else if (in_span && pin_en[sel]) c_bit_o = pin_val[sel] | cs_ser_i;
    else                             c_bit_o = cs_ser_i;
  end

  assign block_start_o = (idx == '0);
  assign cd_mode_o     = pro_ni & fc_ni[1] & fc_ni[0];

  assert_bit0_pro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_start_o && !pro_ni) |-> c_bit_o);
  assert_bit0_con_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_start_o && pro_ni) |-> !c_bit_o);
  assert_ser_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_span |-> c_bit_o == cs_ser_i);
  assert_or_ser_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ser_i && !block_start_o) |-> c_bit_o);
  assert_cd_pro_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pro_ni |-> !cd_mode_o);
endmodule

// File: tb/tb_cs_bit_gen.sv
module tb_cs_bit_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic adv = 1'b0, ser = 1'b0, pro_n = 1'b0;
  logic nonaudio_n = 1'b1, chmode_n = 1'b1, copy_n = 1'b1, cemph_n = 1'b1, gen_n = 1'b1;
  logic [1:0] emph = 2'b00, rate_n = 2'b11, cat_n = 2'b11, fc_n = 2'b00;
  logic c_bit, bstart, cdm;
  int checks = 0, errors = 0, idx = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cs_bit_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_adv_i(adv), .cs_ser_i(ser), .pro_ni(pro_n),
    .pro_nonaudio_ni(nonaudio_n), .emph_i(emph), .pro_rate_ni(rate_n),
    .pro_chmode_ni(chmode_n), .con_copy_ni(copy_n), .con_emph_ni(cemph_n),
    .con_cat_ni(cat_n), .con_gen_ni(gen_n), .fc_ni(fc_n),
    .c_bit_o(c_bit), .block_start_o(bstart), .cd_mode_o(cdm)
  );

  function automatic logic exp_bit(int i, logic s);
    logic b;
    b = s;
    if (i == 0) return ~pro_n;
    if (!pro_n) begin
      case (i)
        1: b = ~nonaudio_n | s;
        2: b = (emph != 2'd3) | s;
        3: b = (emph <= 2'd1) | s;
        4: b = (emph == 2'd0) | s;
        6: b = ~rate_n[0] | s;
        7: b = ~rate_n[1] | s;
        9: b = ~chmode_n | s;
        default: b = s;
      endcase
    end else begin
      case (i)
        2:  b = ~copy_n | s;
        3:  b = ~cemph_n | s;
        8:  b = ~cat_n[0] | s;
        9:  b = ~cat_n[1] | s;
        15: b = ~gen_n | s;
        24: b = ~fc_n[0] | s;
        25: b = ~fc_n[1] | s;
        default: b = s;
      endcase
    end
    return b;
  endfunction

  function automatic string tag(int i);
    if (i == 0) return "R3";
    if (!pro_n && (i >= 2 && i <= 4)) return "R5";
    if (!pro_n && (i == 1 || i == 6 || i == 7 || i == 9)) return "R4";
    if (pro_n && (i == 24 || i == 25)) return "R7";
    if (pro_n && (i == 2 || i == 3 || i == 8 || i == 9 || i == 15)) return "R6";
    return "R8";
  endfunction

  task automatic chk(string r, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s idx=%0d act=%b exp=%b", r, what, idx, act, exp);
    end
  endtask

  // one frame: check outputs for current index, then advance
  task automatic frame(logic s);
    @(negedge clk);
    adv = 1'b0;
    ser = s;
    #2;
    chk(tag(idx), c_bit, exp_bit(idx, s), "c_bit");
    chk((idx == 0 || idx == 191) ? "R2" : "R1", bstart, idx == 0, "block_start");
    adv = 1'b1;
    idx = (idx + 1) % 192;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    adv = 1'b0;
    repeat (n) @(negedge clk);
    #2;
    chk("R1", bstart, idx == 0, "hold block_start");
    chk("R1", c_bit, exp_bit(idx, ser), "hold c_bit");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    chk("R2", bstart, 1'b1, "reset block_start");
    chk("R3", c_bit, 1'b1, "reset c_bit pro");
    rst_n = 1'b1;
    // hold behaviour mid-block
    for (int k = 0; k < 5; k++) frame(1'b0);
    idle(3);
    for (int k = 5; k < 192; k++) frame(1'b0);
    idle(1);
    chk("R2", bstart, 1'b1, "wrap to 0");
    for (int m = 0; m < 2; m++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        pro_n = m[0];
        if (!pro_n) begin
          emph = cfg[1:0];
          {nonaudio_n, chmode_n} = cfg[3:2];
          rate_n = {cfg[2], cfg[3]};
          {copy_n, cemph_n, gen_n} = {~cfg[3], ~cfg[2], cfg[1]};
          cat_n = ~cfg[1:0];
          fc_n = cfg[3:2];
        end else begin
          fc_n = cfg[1:0];
          {copy_n, cemph_n} = cfg[3:2];
          cat_n = {cfg[2], cfg[3]};
          gen_n = cfg[0] ^ cfg[3];
          emph = ~cfg[1:0];
          {nonaudio_n, chmode_n} = ~cfg[3:2];
          rate_n = ~cfg[3:2];
        end
        #1;
        chk("R7", cdm, pro_n && fc_n == 2'b11, "cd_mode");
        for (int k = 0; k < 192; k++) frame(1'b0);
        for (int k = 0; k < 192; k++) frame(1'b1);
      end
    end
    idle(1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule